// File: doc/BRIEF.md
# Down-Counting Timer Bank

The block holds five independent 32-bit down-counters that software controls through a small memory-mapped register window. Every timer has a count buffer, which holds the value the counter reloads from. Timers 0 to 3 also have a compare buffer, which is only stored. The live count of every timer can be read back. The counters advance only on cycles where their own tick-enable input is high, so an external prescaler or event source sets the rate.

A single control register holds a start, manual-update and auto-reload bit for each timer, plus an output-invert bit that is only stored. The block acts on the 0-to-1 transitions of start and manual-update as a write makes them. A combined interrupt register holds per-timer enables and sticky per-timer status flags. There is one interrupt line per timer. The bus is a single-cycle port: a write takes effect at the next clock edge, and read data is combinational on the address.

Top module: `timer_bank_top`

## Requirements
- R1: After a synchronous active-low reset, all of the following are 0: the control register, the interrupt register, every count buffer, every compare buffer, every live count and every interrupt line. All timers are stopped.
- R2: Timer n (0..4) has its count buffer at byte offset 12*n. Timers 0..3 have their compare buffer at 12*n+4 and their live count at 12*n+8. The live count of timer 4 is at 0x40, the interrupt register at 0x44 and the control register at 0x48. The buffers read back what was last written.
- R3: Reads of every other offset return 0, and writes to them change nothing. The live-count registers are read-only.
- R4: A control write that takes a timer's manual-update bit from 0 to 1 loads that timer's count buffer into its counter. A write that leaves the bit at 1 does not reload.
- R5: A timer runs while its start bit is 1. A write that takes the bit from 0 to 1 starts it, and a write of 0 stops it. A running counter decrements by 1 only on a cycle where its tick-enable input is high. A stopped counter holds its value.
- R6: A running counter expires when its count is 0 and a tick arrives. Expiry sets the timer's status flag (interrupt register bit 5+n). If the timer's enable (bit n) is set, expiry also raises that timer's interrupt line on the next cycle.
- R7: On expiry with auto-reload clear, the timer stops and its start bit in the control register reads 0.
- R8: A write to the interrupt register replaces enables 4:0 with the written bits. It clears each status flag in bits 9:5 where a 1 is written, and leaves flags where a 0 is written. Clearing a status flag drops that timer's interrupt line.
- R9: On expiry with auto-reload set, the counter reloads from its count buffer and keeps running, and the start bit stays 1.
- R10: In the control register, timer 0 uses bits 3:0 and timer n (1..3) uses bits 4n+7:4n+4, in the order start, manual-update, invert, auto-reload from the low bit. Timer 4 has start at bit 20, manual-update at bit 21 and auto-reload at bit 22, and no invert bit. Bits outside these groups read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick_en | input | 5 | Per-timer count enable |
| irq | output | 5 | Per-timer interrupt line |

## Verification
The bench loads a counter and writes the manual-update bit a second time while it is already 1. A design that detects levels instead of edges would reload, and the count would jump back. Expiry is driven both with auto-reload clear and with auto-reload set. A wrong design would keep timer 0 running, would fail to clear its start bit, or would leave the reloaded timer parked at 0. Timer 4's irregular auto-reload position is exercised, together with a write of all ones to the control register, so a misplaced group or a stored invert bit on timer 4 shows up in the read-back. Interrupt-register writes of 0 and of 1 to the status bits separate a design that overwrites status from one that clears on 1, and the bench checks that the interrupt line falls with its flag.

// File: rtl/tmr_bank_pkg.sv
// Package: register map and control-bit layout for the timer bank.
// Assumes at most six timers so that every control group fits in 32 bits.
package tmr_bank_pkg;

    localparam int BUS_W = 32;

    // Lowest control bit of timer n's group
    function automatic int grp_base(input int n);
        return (n == 0) ? 0 : (4 * n + 4);
    endfunction

    function automatic int bit_start(input int n);
        return grp_base(n);
    endfunction

    function automatic int bit_load(input int n);
        return grp_base(n) + 1;
    endfunction

    function automatic int bit_inv(input int n);
        return grp_base(n) + 2;
    endfunction

    // The last timer has no invert bit; its auto-reload moves down one place
    function automatic int bit_arl(input int n, input bit last);
        return last ? (grp_base(n) + 2) : (grp_base(n) + 3);
    endfunction

    // Writable control bits for a bank of nt timers
    function automatic logic [BUS_W-1:0] ctrl_mask(input int nt);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int n = 0; n < nt; n++) begin
            m[bit_start(n)]             = 1'b1;
            m[bit_load(n)]              = 1'b1;
            m[bit_arl(n, n == nt - 1)]  = 1'b1;
            if (n != nt - 1) m[bit_inv(n)] = 1'b1;
        end
        return m;
    endfunction

    function automatic int cnt_off(input int n);
        return 12 * n;
    endfunction

    function automatic int cmp_off(input int n);
        return 12 * n + 4;
    endfunction

    function automatic int obs_off(input int n, input int nt);
        return (n == nt - 1) ? (12 * n + 16) : (12 * n + 8);
    endfunction

    function automatic int int_off(input int nt);
        return 12 * (nt - 1) + 20;
    endfunction

    function automatic int ctrl_off(input int nt);
        return 12 * (nt - 1) + 24;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
// Module: one down-counter with its count and compare buffers.
// Does: loads on a manual-update pulse, decrements on tick while running,
//       flags expiry at count 0 and reloads if auto-reload is set.
// Assumes: load and run come from the control register one cycle early.
module tmr_channel #(
    parameter int CW      = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    input  logic          load,
    input  logic          run,
    input  logic          arl,
    input  logic          tick,
    output logic [CW-1:0] cnt_buf,
    output logic [CW-1:0] cmp_buf,
    output logic [CW-1:0] count,
    output logic          expire
);

    logic at_zero;
    assign at_zero = (count == '0);
    assign expire  = run && tick && at_zero && !load;

    // Count buffer: software-written reload value
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_buf <= '0;
        else if (wr_cnt) cnt_buf <= wdata;
    end

    // Compare buffer: stored only, present on channels that have one
    generate
        if (HAS_CMP) begin : g_cmp
            always_ff @(posedge clk) begin
                if (!rst_n)      cmp_buf <= '0;
                else if (wr_cmp) cmp_buf <= wdata;
            end
        end else begin : g_nocmp
            logic unused_cmp;
            assign unused_cmp = wr_cmp;
            assign cmp_buf    = '0;
        end
    endgenerate

    // Counter: manual load first, then tick-driven decrement or reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= cnt_buf;
        end else if (run && tick) begin
            if (!at_zero)  count <= count - CW'(1);
            else if (arl)  count <= cnt_buf;
        end
    end

    AST_LOAD_TAKES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(cnt_buf)); // R4
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count != '0) |=> count == $past(count) - CW'(1)); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(count)); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && arl) |=> count == $past(cnt_buf)); // R9

endmodule

// File: rtl/tmr_ctrl.sv
// Module: control register, interrupt register and interrupt lines.
// Does: edge-detects manual-update on writes, clears start on a
//       non-reloading expiry, keeps write-1-to-clear status flags.
// Assumes: a control write in the same cycle as an expiry wins.
module tmr_ctrl
    import tmr_bank_pkg::*;
#(
    parameter int NT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_int,
    input  logic [BUS_W-1:0] wdata,
    input  logic [NT-1:0]    expire,
    output logic [BUS_W-1:0] ctrl_q,
    output logic [2*NT-1:0]  int_q,
    output logic [NT-1:0]    run,
    output logic [NT-1:0]    arl,
    output logic [NT-1:0]    load,
    output logic [NT-1:0]    irq
);

    localparam logic [BUS_W-1:0] MASK = ctrl_mask(NT);

    logic [BUS_W-1:0] ctrl_nxt;
    logic [NT-1:0]    en_nxt;
    logic [NT-1:0]    st_nxt;
    logic [NT-1:0]    st_clr;

    // Per-timer control decode
    generate
        for (genvar n = 0; n < NT; n++) begin : g_bits
            localparam int S = bit_start(n);
            localparam int L = bit_load(n);
            localparam int A = bit_arl(n, n == NT - 1);
            assign run[n]  = ctrl_q[S];
            assign arl[n]  = ctrl_q[A];
            assign load[n] = wr_ctrl && wdata[L] && !ctrl_q[L];

            AST_STOP_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
                (expire[n] && !arl[n] && !wr_ctrl) |=> !run[n]); // R7
            AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                expire[n] |=> int_q[NT+n]); // R6
            AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
                (expire[n] && int_q[n]) |=> irq[n]); // R6
            AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_int && wdata[NT+n] && !expire[n]) |=> !irq[n]); // R8
        end
    endgenerate

    // Next control value: software write, else hardware stop on expiry
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_ctrl) begin
            ctrl_nxt = wdata & MASK;
        end else begin
            for (int n = 0; n < NT; n++) begin
                if (expire[n] && !arl[n]) ctrl_nxt[bit_start(n)] = 1'b0;
            end
        end
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_nxt;
    end

    // Next interrupt value: enables replaced, status write-1-clear, expiry sets
    always_comb begin
        st_clr = wr_int ? wdata[2*NT-1:NT] : '0;
        en_nxt = wr_int ? wdata[NT-1:0] : int_q[NT-1:0];
        st_nxt = (int_q[2*NT-1:NT] & ~st_clr) | expire;
    end

    // Interrupt register
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= '0;
        else        int_q <= {st_nxt, en_nxt};
    end

    // Interrupt lines: raised on an enabled expiry, dropped when status clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= '0;
        end else begin
            for (int n = 0; n < NT; n++) begin
                if (expire[n] && int_q[n]) irq[n] <= 1'b1;
                else if (st_clr[n])        irq[n] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_bus_map.sv
// Module: address decode and read multiplexer for the register window.
// Does: turns one write strobe into per-register strobes, returns 0 for
//       unmapped offsets and for writes to read-only registers.
// Assumes: byte offsets, word-aligned registers, exact address match.
module tmr_bus_map
    import tmr_bank_pkg::*;
#(
    parameter int NT = 5,
    parameter int CW = 32,
    parameter int AW = 7
) (
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [NT-1:0][CW-1:0] cnt_all,
    input  logic [NT-1:0][CW-1:0] cmp_all,
    input  logic [NT-1:0][CW-1:0] count_all,
    input  logic [BUS_W-1:0]      ctrl_q,
    input  logic [2*NT-1:0]       int_q,
    output logic [NT-1:0]         wr_cnt,
    output logic [NT-1:0]         wr_cmp,
    output logic                  wr_ctrl,
    output logic                  wr_int,
    output logic [BUS_W-1:0]      rdata
);

    // Write strobes per timer
    generate
        for (genvar n = 0; n < NT; n++) begin : g_wr
            assign wr_cnt[n] = bus_wr && (bus_addr == AW'(cnt_off(n)));
            if (n < NT - 1) begin : g_has_cmp
                assign wr_cmp[n] = bus_wr && (bus_addr == AW'(cmp_off(n)));
            end else begin : g_no_cmp
                assign wr_cmp[n] = 1'b0;
            end
        end
    endgenerate

    assign wr_ctrl = bus_wr && (bus_addr == AW'(ctrl_off(NT)));
    assign wr_int  = bus_wr && (bus_addr == AW'(int_off(NT)));

    // Read multiplexer; unmatched offsets read zero
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NT; n++) begin
            if (bus_addr == AW'(cnt_off(n)))     rdata = BUS_W'(cnt_all[n]);
            if ((n < NT - 1) && (bus_addr == AW'(cmp_off(n))))
                                                 rdata = BUS_W'(cmp_all[n]);
            if (bus_addr == AW'(obs_off(n, NT))) rdata = BUS_W'(count_all[n]);
        end
        if (bus_addr == AW'(int_off(NT)))  rdata = BUS_W'(int_q);
        if (bus_addr == AW'(ctrl_off(NT))) rdata = ctrl_q;
    end

endmodule

// File: rtl/timer_bank_top.sv
// Module: bank of down-counting timers behind a single-cycle register port.
// Does: wires the bus map, the control/interrupt registers and one
//       channel per timer; the last timer has no compare buffer.
// Assumes: tick_en is synchronous to clk; CW is at most 32.
module timer_bank_top
    import tmr_bank_pkg::*;
#(
    parameter int NT = 5,
    parameter int CW = 32,
    parameter int AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NT-1:0]    tick_en,
    output logic [NT-1:0]    irq
);

    logic [NT-1:0][CW-1:0] cnt_all;
    logic [NT-1:0][CW-1:0] cmp_all;
    logic [NT-1:0][CW-1:0] count_all;
    logic [NT-1:0]         wr_cnt;
    logic [NT-1:0]         wr_cmp;
    logic                  wr_ctrl;
    logic                  wr_int;
    logic [BUS_W-1:0]      ctrl_q;
    logic [2*NT-1:0]       int_q;
    logic [NT-1:0]         run;
    logic [NT-1:0]         arl;
    logic [NT-1:0]         load;
    logic [NT-1:0]         expire;

    tmr_bus_map #(.NT(NT), .CW(CW), .AW(AW)) u_map (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .cnt_all   (cnt_all),
        .cmp_all   (cmp_all),
        .count_all (count_all),
        .ctrl_q    (ctrl_q),
        .int_q     (int_q),
        .wr_cnt    (wr_cnt),
        .wr_cmp    (wr_cmp),
        .wr_ctrl   (wr_ctrl),
        .wr_int    (wr_int),
        .rdata     (bus_rdata)
    );

    tmr_ctrl #(.NT(NT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_int  (wr_int),
        .wdata   (bus_wdata),
        .expire  (expire),
        .ctrl_q  (ctrl_q),
        .int_q   (int_q),
        .run     (run),
        .arl     (arl),
        .load    (load),
        .irq     (irq)
    );

    generate
        for (genvar n = 0; n < NT; n++) begin : g_ch
            tmr_channel #(.CW(CW), .HAS_CMP(n < NT - 1)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_cnt  (wr_cnt[n]),
                .wr_cmp  (wr_cmp[n]),
                .wdata   (bus_wdata[CW-1:0]),
                .load    (load[n]),
                .run     (run[n]),
                .arl     (arl[n]),
                .tick    (tick_en[n]),
                .cnt_buf (cnt_all[n]),
                .cmp_buf (cmp_all[n]),
                .count   (count_all[n]),
                .expire  (expire[n])
            );
        end
    endgenerate

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> int_q[NT]); // R6

endmodule

// File: tb/timer_bank_top_test.sv
// Scoreboard bench: driver tasks queue expected values with the observed
// ones, and a monitor process pops and compares them.
module timer_bank_top_test;

    localparam logic [6:0] A_CTRL = 7'h48;
    localparam logic [6:0] A_INT  = 7'h44;
    localparam logic [6:0] A_OBS4 = 7'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  irq;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    item_t e_it;
    item_t a_it;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    timer_bank_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    // Monitor: pop and compare every queued pair
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            e_it = exp_q.pop_front();
            a_it = act_q.pop_front();
            checks++;
            if (a_it.val !== e_it.val) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", e_it.tag, a_it.val, e_it.val);
            end
        end
    end

    task automatic push_chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        exp_q.push_back('{val: exp, tag: tag});
        act_q.push_back('{val: act, tag: tag});
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        push_chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic [4:0] exp, input string tag);
        @(negedge clk);
        #1;
        push_chk(tag, {27'd0, irq}, {27'd0, exp});
    endtask

    task automatic ticks(input int n, input logic [4:0] mask);
        @(negedge clk);
        tick_en = mask;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_CTRL, 32'h0, "R1 ctrl after reset");
        rd_chk(A_INT,  32'h0, "R1 int after reset");
        rd_chk(7'h00,  32'h0, "R1 count buffer 0");
        rd_chk(7'h28,  32'h0, "R1 compare buffer 3");
        rd_chk(A_OBS4, 32'h0, "R1 live count 4");
        irq_chk(5'h00, "R1 irq after reset");

        // R2 buffer map and read-back
        wr(7'h18, 32'h1234_5678);
        wr(7'h1C, 32'hCAFE_0001);
        wr(7'h30, 32'h0000_A5A5);
        rd_chk(7'h18, 32'h1234_5678, "R2 count buffer 2");
        rd_chk(7'h1C, 32'hCAFE_0001, "R2 compare buffer 2");
        rd_chk(7'h30, 32'h0000_A5A5, "R2 count buffer 4");

        // R3 unmapped and read-only offsets
        wr(7'h34, 32'hFFFF_FFFF);
        rd_chk(7'h34, 32'h0, "R3 unmapped read");
        rd_chk(7'h30, 32'h0000_A5A5, "R3 neighbour untouched");
        rd_chk(7'h28, 32'h0, "R3 compare 3 untouched");
        wr(7'h14, 32'h77);
        rd_chk(7'h14, 32'h0, "R3 live count read-only");
        rd_chk(7'h4C, 32'h0, "R3 unmapped tail");

        // R4 manual-update edge
        wr(7'h00, 32'd5);
        wr(A_CTRL, 32'h2);
        rd_chk(7'h08, 32'd5, "R4 manual load");
        wr(7'h00, 32'd9);
        wr(A_CTRL, 32'h2);
        rd_chk(7'h08, 32'd5, "R4 no reload without edge");

        // R5 start, tick gating, stop
        ticks(3, 5'h01);
        rd_chk(7'h08, 32'd5, "R5 stopped timer holds");
        wr(A_CTRL, 32'h1);
        rd_chk(7'h08, 32'd5, "R5 running without tick holds");
        ticks(3, 5'h01);
        rd_chk(7'h08, 32'd2, "R5 three ticks");
        wr(A_CTRL, 32'h0);
        ticks(2, 5'h01);
        rd_chk(7'h08, 32'd2, "R5 stop holds count");

        // R6 R7 expiry without auto-reload
        wr(A_INT, 32'h1);
        wr(A_CTRL, 32'h1);
        ticks(2, 5'h01);
        rd_chk(7'h08, 32'd0, "R5 reached zero");
        irq_chk(5'h00, "R6 no irq before expiry");
        ticks(1, 5'h01);
        rd_chk(A_INT, 32'h21, "R6 status set on expiry");
        irq_chk(5'h01, "R6 irq raised");
        rd_chk(A_CTRL, 32'h0, "R7 start cleared on expiry");

        // R8 write-1-clear
        wr(A_INT, 32'h21);
        rd_chk(A_INT, 32'h01, "R8 status cleared, enable kept");
        irq_chk(5'h00, "R8 irq dropped");

        // R9 auto-reload on timer 1
        wr(7'h0C, 32'd3);
        wr(A_CTRL, 32'h0000_0A00);
        rd_chk(7'h14, 32'd3, "R10 timer1 manual bit");
        wr(A_CTRL, 32'h0000_0900);
        ticks(4, 5'h02);
        rd_chk(7'h14, 32'd3, "R9 reloaded");
        rd_chk(A_CTRL, 32'h0000_0900, "R9 start kept");
        rd_chk(A_INT, 32'h41, "R9 status timer1");
        irq_chk(5'h00, "R6 disabled timer no irq");
        ticks(2, 5'h02);
        rd_chk(7'h14, 32'd1, "R9 keeps running");

        // R10 timer 4 layout
        wr(7'h30, 32'd2);
        wr(A_INT, 32'h11);
        rd_chk(A_INT, 32'h51, "R8 zero write keeps status");
        wr(A_CTRL, 32'h0060_0000);
        rd_chk(A_OBS4, 32'd2, "R10 timer4 manual bit 21");
        wr(A_CTRL, 32'h0050_0000);
        ticks(3, 5'h10);
        rd_chk(A_OBS4, 32'd2, "R10 timer4 auto-reload bit 22");
        irq_chk(5'h10, "R10 timer4 irq");
        rd_chk(A_INT, 32'h251, "R10 timer4 status bit 9");
        rd_chk(A_CTRL, 32'h0050_0000, "R10 timer4 start bit 20 kept");
        rd_chk(7'h14, 32'd1, "R5 timer1 stopped by write");
        ticks(1, 5'h10);
        rd_chk(A_OBS4, 32'd1, "R10 timer4 counting");

        // R10 writable-bit mask
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk(A_CTRL, 32'h007F_FF0F, "R10 control mask");
        wr(A_INT, 32'h3E0);
        rd_chk(A_INT, 32'h0, "R8 all status and enables cleared");
        irq_chk(5'h00, "R8 all irq low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule